// File: doc/BRIEF.md
# Pixel Clock-Enable Pair Generator

This block derives two video timing enables from the memory clock: a pixel enable and a double-rate pixel enable. Each enable is a one-cycle strobe that downstream video logic uses to advance its state, so no second clock is needed. The two strobes share one phase reference. Every pixel-rate strobe lands in the same cycle as a double-rate strobe.

Two elaboration-time parameters fix the configuration. `PIXEL_MHZ` selects a pixel rate of 6, 8 or 12 MHz. `MEM_FAST` states whether the memory clock runs at 48 MHz (0) or 96 MHz (1). When the memory clock is 96 MHz, every divide ratio doubles, so the output rates are the same in both cases. Any other pixel setting stops elaboration with an error.

Top module: `pxl_cen_gen`

## Requirements
- R1: While `rst_n` is sampled low, `pxl_cen` and `pxl2_cen` are both 0 from the cycle after that edge onward.
- R2: After reset is released, both enables are high in the cycle that follows the first rising edge that samples `rst_n` high.
- R3: `pxl_cen` is high once every D cycles, where D is 8, 6 or 4 for the 6, 8 or 12 MHz settings with `MEM_FAST`=0, and twice that (16, 12 or 8) with `MEM_FAST`=1.
- R4: `pxl2_cen` is high once every D/2 cycles, which gives twice the `pxl_cen` rate, with pulses evenly spaced.
- R5: Every cycle in which `pxl_cen` is high also has `pxl2_cen` high.
- R6: Neither enable is ever high on two consecutive cycles. Every active cycle is followed by at least one idle cycle.
- R7: Asserting reset in the middle of operation and releasing it again restarts both enables in the phase given by R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory clock, 48 or 96 MHz |
| rst_n | input | 1 | Synchronous active-low reset |
| pxl_cen | output | 1 | Pixel-rate one-cycle enable |
| pxl2_cen | output | 1 | Double-pixel-rate one-cycle enable |

## Verification
The two enables coincide at the start of every pixel period. At every other double-rate position, `pxl2_cen` fires alone. All six parameter combinations run side by side from one reset, which produces both the coincident cycles and the solo cycles in every configuration. A behavioural reference computes both expected strobes from the cycle index since reset release and checks them on every clock. Over each window the bench also confirms that `pxl_cen` never appears without `pxl2_cen` and that neither enable repeats on the next cycle.

// File: rtl/pxl_cen_pkg.sv
// Shared helpers for the pixel enable generator.
// Assumes the pixel setting is one of 6, 8 or 12; other values map to 0.
package pxl_cen_pkg;

    // Memory-clock cycles per pixel-enable period; doubled for the fast clock.
    function automatic int unsigned pxl_div_ratio(input int unsigned mhz, input bit fast);
        int unsigned base;
        case (mhz)
            6:       base = 8;
            8:       base = 6;
            12:      base = 4;
            default: base = 0;
        endcase
        return fast ? base * 2 : base;
    endfunction

endpackage

// File: rtl/cen_phase_counter.sv
// Free-running modulo-DIV phase counter.
// Assumes DIV >= 2. Synchronous active-low reset returns the phase to 0.
module cen_phase_counter #(
    parameter int unsigned DIV = 8,
    parameter int unsigned CW  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] phase
);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    // Advance the phase by one and wrap to 0 after the last step.
    always_ff @(posedge clk) begin
        if (!rst_n)             phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
    end

endmodule

// File: rtl/cen_pulse_decode.sv
// Turns the phase count into registered enable strobes.
// The pixel strobe fires at phase 0. The double-rate strobe fires at phase 0
// and at phase DIV/2. Assumes DIV is even and at least 4.
module cen_pulse_decode #(
    parameter int unsigned DIV = 8,
    parameter int unsigned CW  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] phase,
    output logic          pxl_cen,
    output logic          pxl2_cen
);
    localparam logic [CW-1:0] HALF = CW'(DIV / 2);

    // Register both strobes from the current phase; cleared in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pxl_cen  <= 1'b0;
            pxl2_cen <= 1'b0;
        end else begin
            pxl_cen  <= (phase == '0);
            pxl2_cen <= (phase == '0) || (phase == HALF);
        end
    end

    // R5: a pixel strobe never appears without the double-rate strobe.
    a_r5_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        pxl_cen |-> pxl2_cen);

    // R6: the pixel strobe is followed by an idle cycle.
    a_r6_pxl_idle_after: assert property (@(posedge clk) disable iff (!rst_n)
        pxl_cen |=> !pxl_cen);

    // R6: the double-rate strobe is followed by an idle cycle.
    a_r6_pxl2_idle_after: assert property (@(posedge clk) disable iff (!rst_n)
        pxl2_cen |=> !pxl2_cen);

endmodule

// File: rtl/pxl_cen_gen.sv
// Pixel clock-enable pair generator.
// Derives a pixel-rate strobe and a double-rate strobe from the memory clock.
// PIXEL_MHZ must be 6, 8 or 12. MEM_FAST=1 means the memory clock is 96 MHz,
// so the divide ratio doubles and the output rates stay fixed.
module pxl_cen_gen
    import pxl_cen_pkg::*;
#(
    parameter int unsigned PIXEL_MHZ = 6,
    parameter bit          MEM_FAST  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    output logic pxl_cen,
    output logic pxl2_cen
);
    localparam int unsigned DIV = pxl_div_ratio(PIXEL_MHZ, MEM_FAST);
    localparam int unsigned CW  = (DIV > 2) ? $clog2(DIV) : 1;

    generate
        if (DIV == 0) begin : g_bad_setting
            $error("pxl_cen_gen: PIXEL_MHZ must be 6, 8 or 12");
        end
    endgenerate

    logic [CW-1:0] phase;

    cen_phase_counter #(.DIV(DIV), .CW(CW)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    cen_pulse_decode #(.DIV(DIV), .CW(CW)) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .pxl_cen  (pxl_cen),
        .pxl2_cen (pxl2_cen)
    );

    // R2 / R7: both strobes appear in the cycle after reset release.
    a_r2_first_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |=> (pxl_cen && pxl2_cen));

endmodule

// File: tb/pxl_cen_gen_bench.sv
// Runs all six configurations side by side against a behavioural reference.
module pxl_cen_gen_bench;
    localparam int NCFG = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCFG-1:0] pc, p2;
    int cfg_mhz [NCFG];
    int cfg_fast[NCFG];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    for (genvar g = 0; g < NCFG; g++) begin : cfg
        localparam int unsigned P = (g % 3 == 0) ? 6 : ((g % 3 == 1) ? 8 : 12);
        localparam bit F = (g >= 3);
        initial begin
            cfg_mhz[g]  = P;
            cfg_fast[g] = F;
        end
        pxl_cen_gen #(.PIXEL_MHZ(P), .MEM_FAST(F)) u_pxl_cen_gen (
            .clk      (clk),
            .rst_n    (rst_n),
            .pxl_cen  (pc[g]),
            .pxl2_cen (p2[g])
        );
    end

    task automatic check(input bit ok, input string req, input int g,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cfg%0d (%0d MHz, fast=%0d): actual %0d expected %0d",
                     req, g, cfg_mhz[g], cfg_fast[g], act, exp);
        end
    endtask

    // Reset-state check over several cycles (R1).
    task automatic hold_reset(input int n);
        rst_n = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            for (int g = 0; g < NCFG; g++) begin
                check(pc[g] == 1'b0, "R1 pxl_cen in reset", g, pc[g], 0);
                check(p2[g] == 1'b0, "R1 pxl2_cen in reset", g, p2[g], 0);
            end
        end
        rst_n = 1'b1;
    endtask

    // Window after release: k counts cycles from the first strobe cycle.
    task automatic run_window(input int n, input string tag);
        int c1[NCFG];
        int c2[NCFG];
        bit prev1[NCFG];
        bit prev2[NCFG];
        for (int g = 0; g < NCFG; g++) begin
            c1[g] = 0; c2[g] = 0; prev1[g] = 0; prev2[g] = 0;
        end
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            for (int g = 0; g < NCFG; g++) begin
                int d;
                bit e1, e2;
                d  = (48 * (1 + cfg_fast[g])) / cfg_mhz[g];
                e1 = (k % d == 0);
                e2 = (k % (d / 2) == 0);
                if (k == 0) begin
                    check(pc[g] == 1'b1, {tag, " first pxl_cen"}, g, pc[g], 1);
                    check(p2[g] == 1'b1, {tag, " first pxl2_cen"}, g, p2[g], 1);
                end else begin
                    check(pc[g] == e1, "R3 pxl_cen cycle", g, pc[g], e1);
                    check(p2[g] == e2, "R4 pxl2_cen cycle", g, p2[g], e2);
                end
                if (pc[g]) check(p2[g] == 1'b1, "R5 coincidence", g, p2[g], 1);
                if (prev1[g]) check(pc[g] == 1'b0, "R6 pxl_cen idle", g, pc[g], 0);
                if (prev2[g]) check(p2[g] == 1'b0, "R6 pxl2_cen idle", g, p2[g], 0);
                prev1[g] = pc[g];
                prev2[g] = p2[g];
                c1[g] += pc[g];
                c2[g] += p2[g];
            end
        end
        for (int g = 0; g < NCFG; g++) begin
            int d;
            d = (48 * (1 + cfg_fast[g])) / cfg_mhz[g];
            check(c1[g] == n / d, "R3 pxl_cen count", g, c1[g], n / d);
            check(c2[g] == 2 * n / d, "R4 pxl2_cen count", g, c2[g], 2 * n / d);
        end
    endtask

    initial begin
        @(negedge clk);
        hold_reset(4);
        run_window(960, "R2");
        hold_reset(3);
        run_window(480, "R7");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule